// File: doc/BRIEF.md
# Subcode Q CRC Serial Reader

This block gathers the Q channel of the disc subcode, one bit per EFM frame, and builds a 96-bit Q block. Each block starts at a frame flagged by the block-sync strobe. The block then carries two sync frames with no Q bit, followed by 80 data bits and 16 check bits. At the end of each block a CRC-16 is computed over the data bits and compared with the received check field. Only a block that passes this comparison is copied into a holding register and offered to the host.

A ready flag tells the host that a checked block is waiting. The host reads it through a read clock that it drives itself. The same clock also serves command entry, so a read/write select input decides whether the clock edges act on the Q readout or are left for the command path. Bits leave LSB first. The host samples each bit on a rising edge, and the block moves to the next bit on the following falling edge. Frame strobes and host pins are treated as inputs synchronous to `clk`.

Top module: `subq_crc_reader`

## Requirements
- R1: After reset, `q_ready` is 0 and `q_sout` is 0.
- R2: When a block passes its check, `q_ready` goes to 1 and `q_sout` presents data bit 0. Data bit k is the k-th Q bit received in the block, counting from 0.
- R3: The check uses CRC-16 with polynomial 0x1021 and initial value 0, fed the 80 data bits in arrival order. The 16 check bits arrive MSB first and are inverted before comparison. A block that fails leaves `q_ready` and the held data unchanged.
- R4: A frame strobe with `sub_sync` high is frame 0 of a block. Frames 0 and 1 carry no Q bit. Frames 2..81 carry data bits 0..79 and frames 82..97 carry the check bits. Strobes received before any sync frame are ignored.
- R5: With `host_rd` high during a readout, each falling edge of `host_clk` moves `q_sout` to the next higher data bit. A rising edge leaves `q_sout` unchanged. After the 80th falling edge `q_sout` is 0.
- R6: The first rising edge of `host_clk` with `host_rd` high while `q_ready` is 1 clears `q_ready` and starts a readout.
- R7: While `host_rd` is low, `host_clk` edges change neither `q_ready` nor `q_sout`.
- R8: A block that passes while a readout is in progress is not latched: the readout continues with the old data and `q_ready` stays 0. The readout ends after 80 falling edges, or as soon as `host_rd` goes low.
- R9: A passing block that arrives while `q_ready` is 1 and no readout is in progress replaces the held data.
- R10: A sync strobe in the middle of a block abandons that block and restarts assembly at frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_stb | input | 1 | One-cycle strobe per subcode frame |
| sub_sync | input | 1 | With `sub_stb`: this frame is frame 0 of a block |
| sub_q | input | 1 | Q bit of the strobed frame |
| host_clk | input | 1 | Host read clock, shared with command entry |
| host_rd | input | 1 | 1 selects Q readout, 0 leaves the clock to command entry |
| q_ready | output | 1 | A checked Q block is waiting |
| q_sout | output | 1 | Serial Q data, LSB first |

## Verification
The assertions watch several rules on every cycle. A rising edge that starts a readout must clear the ready flag. Ready and readout-in-progress must never be true together. The held data must stay frozen between falling edges of a readout and whenever the select is low. Each falling edge must move the next bit onto the output. The frame counter must stay in range and a sync strobe must restart it. Whether the CRC arithmetic, the inverted check field and the frame alignment are right shows only in the bench scenarios. The bench sends good, corrupted, unsynchronised and interrupted blocks, and checks the full 80-bit readout order against values it computes itself.

// File: rtl/sqr_pkg.sv
package sqr_pkg;
   localparam int unsigned SQR_DATA_BITS   = 80;
   localparam int unsigned SQR_CRC_BITS    = 16;
   localparam int unsigned SQR_SYNC_FRAMES = 2;
   localparam logic [15:0] SQR_POLY        = 16'h1021;

   typedef enum logic [1:0] {
      FK_IDLE  = 2'd0,
      FK_SYNC  = 2'd1,
      FK_DATA  = 2'd2,
      FK_CHECK = 2'd3
   } frame_kind_e;
endpackage

// File: rtl/sqr_crc_engine.sv
module sqr_crc_engine #(
   parameter int unsigned W = 16,
   parameter logic [W-1:0] POLY = 16'h1021
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] crc
);
   logic         fb;
   logic [W-1:0] nxt;

   always_comb begin
      fb  = din ^ crc[W-1];
      nxt = {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) crc <= '0;
      else if (en)       crc <= nxt;
   end
endmodule

// File: rtl/sqr_frame_sequencer.sv
module sqr_frame_sequencer
   import sqr_pkg::*;
#(
   parameter int unsigned DATA_BITS   = 80,
   parameter int unsigned CRC_BITS    = 16,
   parameter int unsigned SYNC_FRAMES = 2,
   localparam int unsigned BLOCK_FRAMES = SYNC_FRAMES + DATA_BITS + CRC_BITS,
   localparam int unsigned FW = $clog2(BLOCK_FRAMES + 1),
   localparam int unsigned IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stb,
   input  logic          sync,
   output frame_kind_e   kind,
   output logic [IW-1:0] qidx,
   output logic          restart,
   output logic          last
);
   logic [FW-1:0] cnt;
   logic [FW-1:0] cur;

   always_comb begin
      if (sync)                          cur = '0;
      else if (cnt < FW'(BLOCK_FRAMES))  cur = cnt + 1'b1;
      else                               cur = FW'(BLOCK_FRAMES);
   end

   always_comb begin
      if (!stb)                                       kind = FK_IDLE;
      else if (cur < FW'(SYNC_FRAMES))                kind = FK_SYNC;
      else if (cur < FW'(SYNC_FRAMES + DATA_BITS))    kind = FK_DATA;
      else if (cur < FW'(BLOCK_FRAMES))               kind = FK_CHECK;
      else                                            kind = FK_IDLE;
   end

   assign qidx    = IW'(cur - FW'(SYNC_FRAMES));
   assign restart = stb && sync;
   assign last    = stb && (cur == FW'(BLOCK_FRAMES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt <= FW'(BLOCK_FRAMES);
      else if (stb) cnt <= cur;
   end

   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FW'(BLOCK_FRAMES));
   p_sync_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && sync) |=> (cnt == '0));
endmodule

// File: rtl/sqr_block_checker.sv
module sqr_block_checker
   import sqr_pkg::*;
#(
   parameter int unsigned DATA_BITS = 80,
   parameter int unsigned CRC_BITS  = 16,
   parameter logic [CRC_BITS-1:0] POLY = 16'h1021,
   parameter bit INV_CHECK = 1'b1,
   localparam int unsigned IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  frame_kind_e          kind,
   input  logic [IW-1:0]        qidx,
   input  logic                 restart,
   input  logic                 last,
   input  logic                 qbit,
   output logic [DATA_BITS-1:0] data,
   output logic                 done,
   output logic                 pass
);
   logic [CRC_BITS-1:0] rcv;
   logic [CRC_BITS-1:0] calc;
   logic [CRC_BITS-1:0] expect_crc;

   sqr_crc_engine #(.W(CRC_BITS), .POLY(POLY)) u_crc (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (restart),
      .en   (kind == FK_DATA),
      .din  (qbit),
      .crc  (calc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data <= '0;
         rcv  <= '0;
         done <= 1'b0;
      end else begin
         done <= last;
         if (kind == FK_DATA)  data[qidx] <= qbit;
         if (kind == FK_CHECK) rcv <= {rcv[CRC_BITS-2:0], qbit};
      end
   end

   generate
      if (INV_CHECK) begin : g_inv
         assign expect_crc = ~rcv;
      end else begin : g_plain
         assign expect_crc = rcv;
      end
   endgenerate

   assign pass = done && (calc == expect_crc);

   p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/sqr_host_port.sv
module sqr_host_port #(
   parameter int unsigned DATA_BITS = 80,
   localparam int unsigned CW = $clog2(DATA_BITS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [DATA_BITS-1:0] din,
   input  logic                 host_clk,
   input  logic                 host_rd,
   output logic                 ready,
   output logic                 sout
);
   logic                 hclk_q;
   logic                 busy;
   logic [CW-1:0]        cnt;
   logic [DATA_BITS-1:0] shreg;
   logic                 rise;
   logic                 fall;

   assign rise = host_rd &&  host_clk && !hclk_q;
   assign fall = host_rd && !host_clk &&  hclk_q;
   assign sout = shreg[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hclk_q <= 1'b0;
         busy   <= 1'b0;
         ready  <= 1'b0;
         cnt    <= '0;
         shreg  <= '0;
      end else begin
         hclk_q <= host_clk;
         if (busy) begin
            if (!host_rd) begin
               busy <= 1'b0;
            end else if (fall) begin
               shreg <= shreg >> 1;
               cnt   <= cnt + 1'b1;
               if (cnt == CW'(DATA_BITS - 1)) busy <= 1'b0;
            end
         end else if (rise && ready) begin
            busy  <= 1'b1;
            ready <= 1'b0;
            cnt   <= '0;
         end else if (load) begin
            shreg <= din;
            ready <= 1'b1;
         end
      end
   end

   p_ready_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && ready && !busy) |=> !ready);
   p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(ready && busy));
   p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fall) |=> $stable(shreg));
   p_cmd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_rd && !load) |=> ($stable(shreg) && $stable(ready)));
   p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && fall) |=> (sout == $past(shreg[1])));
endmodule

// File: rtl/subq_crc_reader.sv
module subq_crc_reader
   import sqr_pkg::*;
#(
   parameter int unsigned DATA_BITS   = SQR_DATA_BITS,
   parameter int unsigned CRC_BITS    = SQR_CRC_BITS,
   parameter int unsigned SYNC_FRAMES = SQR_SYNC_FRAMES,
   parameter logic [CRC_BITS-1:0] POLY = SQR_POLY,
   parameter bit INV_CHECK = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sub_stb,
   input  logic sub_sync,
   input  logic sub_q,
   input  logic host_clk,
   input  logic host_rd,
   output logic q_ready,
   output logic q_sout
);
   localparam int unsigned IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

   generate
      if (DATA_BITS < 2 || CRC_BITS < 2 || SYNC_FRAMES < 1) begin : g_bad_cfg
         $fatal(1, "subq_crc_reader: unsupported geometry");
      end
   endgenerate

   frame_kind_e          kind;
   logic [IW-1:0]        qidx;
   logic                 restart;
   logic                 last;
   logic [DATA_BITS-1:0] data;
   logic                 done;
   logic                 pass;

   sqr_frame_sequencer #(
      .DATA_BITS(DATA_BITS), .CRC_BITS(CRC_BITS), .SYNC_FRAMES(SYNC_FRAMES)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .stb(sub_stb), .sync(sub_sync),
      .kind(kind), .qidx(qidx), .restart(restart), .last(last)
   );

   sqr_block_checker #(
      .DATA_BITS(DATA_BITS), .CRC_BITS(CRC_BITS), .POLY(POLY), .INV_CHECK(INV_CHECK)
   ) u_chk (
      .clk(clk), .rst_n(rst_n), .kind(kind), .qidx(qidx), .restart(restart),
      .last(last), .qbit(sub_q), .data(data), .done(done), .pass(pass)
   );

   sqr_host_port #(.DATA_BITS(DATA_BITS)) u_host (
      .clk(clk), .rst_n(rst_n), .load(pass), .din(data),
      .host_clk(host_clk), .host_rd(host_rd), .ready(q_ready), .sout(q_sout)
   );

   p_load_needs_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && !q_ready) |=> !q_ready || $past(host_rd));
endmodule

// File: tb/subq_crc_reader_test.sv
module subq_crc_reader_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sub_stb = 1'b0, sub_sync = 1'b0, sub_q = 1'b0;
   logic host_clk = 1'b0, host_rd = 1'b0;
   logic q_ready, q_sout;
   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   subq_crc_reader uut (
      .clk(clk), .rst_n(rst_n), .sub_stb(sub_stb), .sub_sync(sub_sync),
      .sub_q(sub_q), .host_clk(host_clk), .host_rd(host_rd),
      .q_ready(q_ready), .q_sout(q_sout)
   );

   localparam logic [79:0] DA = 80'h1234_5678_9ABC_DEF0_1357;
   localparam logic [79:0] DB = 80'hF0E1_D2C3_B4A5_9687_7869;
   localparam logic [79:0] DC = 80'hA5A5_0F0F_3C3C_C3C3_8001;
   localparam logic [79:0] DD = 80'h0000_FFFF_0000_FFFF_5555;
   localparam logic [79:0] DE = 80'h8421_8421_7BDE_7BDE_0246;

   task automatic chk(string req, logic [79:0] act, logic [79:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] crc16(logic [79:0] d);
      logic [15:0] c = '0;
      for (int i = 0; i < 80; i++) begin
         logic fb = d[i] ^ c[15];
         c = {c[14:0], 1'b0};
         if (fb) c = c ^ 16'h1021;
      end
      return c;
   endfunction

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_frame(bit s, bit b);
      sub_stb = 1'b1; sub_sync = s; sub_q = b;
      tick(1);
      sub_stb = 1'b0; sub_sync = 1'b0; sub_q = 1'b0;
      tick(2);
   endtask

   task automatic send_block(logic [79:0] d, bit good);
      logic [15:0] c = crc16(d);
      if (good) c = ~c;
      send_frame(1'b1, 1'b1);
      send_frame(1'b0, 1'b1);
      for (int k = 0; k < 80; k++) send_frame(1'b0, d[k]);
      for (int k = 0; k < 16; k++) send_frame(1'b0, c[15-k]);
      tick(3);
   endtask

   task automatic read_span(logic [79:0] d, int from, int upto);
      for (int i = from; i <= upto; i++) begin
         host_clk = 1'b1; tick(2);
         chk("R5 rise keeps bit", 80'(q_sout), 80'(d[i]));
         host_clk = 1'b0; tick(2);
         chk("R5 fall advances", 80'(q_sout), (i < 79) ? 80'(d[i+1]) : 80'd0);
      end
   endtask

   task automatic t_reset;
      chk("R1 ready after reset", 80'(q_ready), 80'd0);
      chk("R1 sout after reset", 80'(q_sout), 80'd0);
   endtask

   task automatic t_no_sync;
      logic [15:0] c = ~crc16(DA);
      for (int k = 0; k < 80; k++) send_frame(1'b0, DA[k]);
      for (int k = 0; k < 16; k++) send_frame(1'b0, c[15-k]);
      tick(3);
      chk("R4 unsynced frames ignored", 80'(q_ready), 80'd0);
   endtask

   task automatic t_full_read;
      send_block(DA, 1'b1);
      chk("R2 ready raised", 80'(q_ready), 80'd1);
      chk("R2 bit0 presented", 80'(q_sout), 80'(DA[0]));
      host_rd = 1'b1;
      host_clk = 1'b1; tick(2);
      chk("R6 ready cleared on first rise", 80'(q_ready), 80'd0);
      chk("R5 first bit", 80'(q_sout), 80'(DA[0]));
      host_clk = 1'b0; tick(2);
      chk("R5 second bit", 80'(q_sout), 80'(DA[1]));
      read_span(DA, 1, 79);
      chk("R8 ready low after readout", 80'(q_ready), 80'd0);
      host_rd = 1'b0; tick(2);
   endtask

   task automatic t_replace;
      send_block(DA, 1'b1);
      send_block(DB, 1'b1);
      chk("R9 ready after second block", 80'(q_ready), 80'd1);
      chk("R9 data replaced", 80'(q_sout), 80'(DB[0]));
      host_rd = 1'b1;
      read_span(DB, 0, 5);
      host_rd = 1'b0; tick(2);
      chk("R8 abort leaves ready low", 80'(q_ready), 80'd0);
   endtask

   task automatic t_bad_crc;
      send_block(DD, 1'b0);
      chk("R3 failing block after idle", 80'(q_ready), 80'd0);
      send_block(DC, 1'b1);
      chk("R3 good block accepted", 80'(q_ready), 80'd1);
      send_block(DB, 1'b0);
      chk("R3 failing block keeps ready", 80'(q_ready), 80'd1);
      chk("R3 failing block keeps data", 80'(q_sout), 80'(DC[0]));
   endtask

   task automatic t_cmd_mode;
      host_rd = 1'b0;
      for (int k = 0; k < 6; k++) begin
         host_clk = ~host_clk; tick(2);
      end
      host_clk = 1'b0; tick(2);
      chk("R7 ready kept in command mode", 80'(q_ready), 80'd1);
      chk("R7 sout kept in command mode", 80'(q_sout), 80'(DC[0]));
   endtask

   task automatic t_busy_block;
      host_rd = 1'b1; tick(1);
      host_clk = 1'b1; tick(2);
      chk("R6 ready cleared", 80'(q_ready), 80'd0);
      send_block(DD, 1'b1);
      chk("R8 no ready during readout", 80'(q_ready), 80'd0);
      chk("R8 old data kept", 80'(q_sout), 80'(DC[0]));
      host_clk = 1'b0; tick(2);
      chk("R8 readout continues", 80'(q_sout), 80'(DC[1]));
      read_span(DC, 1, 79);
      chk("R8 ready low after busy block", 80'(q_ready), 80'd0);
      host_rd = 1'b0; tick(2);
   endtask

   task automatic t_restart;
      send_frame(1'b1, 1'b0);
      for (int k = 0; k < 40; k++) send_frame(1'b0, 1'b1);
      send_block(DE, 1'b1);
      chk("R10 restarted block ready", 80'(q_ready), 80'd1);
      chk("R10 restarted block data", 80'(q_sout), 80'(DE[0]));
      host_rd = 1'b1;
      read_span(DE, 0, 7);
      host_rd = 1'b0; tick(2);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_no_sync();
      t_full_read();
      t_replace();
      t_bad_crc();
      t_cmd_mode();
      t_busy_block();
      t_restart();
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule